// File: doc/BRIEF.md
# Text-Mode Character Pixel Renderer

This block turns the current raster position into one 6-bit colour for a text screen of 32 columns by 16 rows. A character-code RAM and an attribute RAM each hold one byte for each of the 512 cells. A font ROM supplies 8x8 glyphs for 192 codes. Each cell occupies 16x24 screen pixels, so every glyph pixel covers two screen pixels across and three screen lines down. The attribute byte picks a foreground palette index and a background palette index. Each index looks up its own 16-entry table of 6-bit colours. The glyph bit chooses between the two colours, and anything outside the active window is forced to black.

The raster timing logic supplies the horizontal and vertical pixel counts, the two active flags, the glyph row index, and the two sync levels. The block delays the sync levels by exactly the latency of its pixel pipeline, so they leave aligned with the colour. A host loads both RAMs through a single synchronous write port. That port runs independently of the display reads and may write in the same cycle as a read.

Top module: `txt_pixel_render`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears `rgb`, `hsync_out` and `vsync_out` to 0.
- R2: A raster position presented before clock edge k appears on `rgb` after edge k+2, which is a fixed latency of three registers.
- R3: The cell address is row*32 + column. The column is `hcount`/16 and the row is `vcount`/24. The glyph bit column is (`hcount`/2) mod 8, where 0 is the leftmost bit and bit 7 of the font byte is the leftmost pixel. Both screen pixels of a doubled glyph pixel show the same colour.
- R4: The font byte is read at address code*8 + `font_row`. By default the byte for code c and row r is ((c*8 + r) mod 256) XOR 0x5A. Codes 192 to 255 read as 0x00.
- R5: The attribute byte holds the foreground index in bits 7:4 and the background index in bits 3:0. A glyph bit of 1 selects the foreground colour and a glyph bit of 0 selects the background colour. Colour words are {blue[1:0], green[1:0], red[1:0]}. Both default palettes, for indexes 0 to 15, are 00,3F,03,3C,33,0C,30,0F,07,02,17,15,2A,3E,1C,2F (hex).
- R6: `rgb` is 0 whenever `h_act` AND `v_act` was low at the position's sampling edge.
- R7: `hsync_out` and `vsync_out` equal `hsync_in` and `vsync_in` delayed by the same three edges as `rgb`.
- R8: When `wr_en` is high, the write port stores `wr_data` at `wr_addr`. `wr_sel` = 0 selects the character RAM and `wr_sel` = 1 selects the attribute RAM. A display read of the same address at the same edge returns the old byte, and the new byte is returned from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount | input | 10 | Horizontal pixel count |
| vcount | input | 10 | Vertical line count |
| h_act | input | 1 | Horizontal position inside text window |
| v_act | input | 1 | Vertical position inside text window |
| font_row | input | 3 | Glyph row for the current line (0 = top) |
| hsync_in | input | 1 | Horizontal sync level to be delayed |
| vsync_in | input | 1 | Vertical sync level to be delayed |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = character RAM, 1 = attribute RAM |
| wr_addr | input | 9 | Cell address to write |
| wr_data | input | 8 | Byte to write |
| rgb | output | 6 | Registered pixel colour {B,G,R} |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |

## Verification
A host write and the display read of the same cell can fall in the same clock edge. The bench provokes this case by driving `wr_en` with the same address as the raster position that is being shown. It then holds that position steady. The pixel that leaves three edges later must still show the old glyph, and the pixel one edge after that must show the glyph of the newly written code.

// File: rtl/txt_pkg.sv
// txt_pkg: shared constants and default contents for the text renderer.
// Assumes 8x8 glyphs and 6-bit colour words {B,G,R}.
package txt_pkg;
    localparam int GLYPH_W = 8;
    localparam int GLYPH_H = 8;
    localparam int COLOR_W = 6;
    localparam int PAL_N   = 16;

    // Default palette; index 0 is black, 1 white, 2 red.
    localparam logic [PAL_N*COLOR_W-1:0] PAL_DEFAULT = {
        6'h2F, 6'h1C, 6'h3E, 6'h2A, 6'h15, 6'h17, 6'h02, 6'h07,
        6'h0F, 6'h30, 6'h0C, 6'h33, 6'h3C, 6'h03, 6'h3F, 6'h00};

    // Compute a placeholder font: byte(c,r) = ((c*8+r) mod 256) ^ 0x5A.
    function automatic logic [GLYPH_H*GLYPH_W*192-1:0] font_default();
        logic [GLYPH_H*GLYPH_W*192-1:0] v;
        v = '0;
        for (int a = 0; a < 192*GLYPH_H; a++) begin
            v[a*8 +: 8] = 8'(a) ^ 8'h5A;
        end
        return v;
    endfunction
endpackage

// File: rtl/txt_dpram.sv
// txt_dpram: one write port, one read port, registered read.
// Assumes read-first behaviour on an address collision (old data out).
module txt_dpram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store on write strobe; read the pre-write contents every edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/txt_font_rom.sv
// txt_font_rom: glyph bitmap ROM, one byte per glyph row, registered output.
// Assumes address = code*GLYPH_H + row; codes beyond NGLYPH read as zero.
module txt_font_rom #(
    parameter int NGLYPH = 192,
    parameter logic [NGLYPH*64-1:0] FONT_BITS = txt_pkg::font_default(),
    localparam int AW = $clog2(256*txt_pkg::GLYPH_H)
) (
    input  logic          clk,
    input  logic [7:0]    code,
    input  logic [2:0]    row,
    output logic [7:0]    bits
);
    localparam int DEPTH = NGLYPH * txt_pkg::GLYPH_H;
    logic [AW-1:0] addr;

    // Combine code and glyph row into a linear byte address.
    always_comb addr = {code, row};

    // Registered lookup with zero for out-of-range codes.
    always_ff @(posedge clk) begin
        if (int'(addr) < DEPTH) begin
            bits <= FONT_BITS[addr*8 +: 8];
        end else begin
            bits <= 8'h00;
        end
    end
endmodule

// File: rtl/txt_palette.sv
// txt_palette: 16-entry table of 6-bit colours, combinational lookup.
// Assumes the caller registers the result.
module txt_palette #(
    parameter logic [txt_pkg::PAL_N*txt_pkg::COLOR_W-1:0] TABLE = txt_pkg::PAL_DEFAULT
) (
    input  logic [3:0]                  idx,
    output logic [txt_pkg::COLOR_W-1:0] color
);
    // Select the word for the given index.
    always_comb color = TABLE[idx*txt_pkg::COLOR_W +: txt_pkg::COLOR_W];
endmodule

// File: rtl/txt_pixel_render.sv
// txt_pixel_render: raster position to registered 6-bit pixel colour.
// Pipeline: E0 RAM reads, E1 font read + palette, E2 select/gate -> rgb.
// Assumes the caller supplies font_row = glyph row of the current line and
// active flags that are already window-qualified.
module txt_pixel_render #(
    parameter int COLS   = 32,
    parameter int ROWS   = 16,
    parameter int CELL_W = 16,
    parameter int CELL_H = 24,
    parameter int NGLYPH = 192,
    parameter logic [NGLYPH*64-1:0] FONT_BITS = txt_pkg::font_default(),
    parameter logic [95:0] FG_PAL = txt_pkg::PAL_DEFAULT,
    parameter logic [95:0] BG_PAL = txt_pkg::PAL_DEFAULT,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int AW    = COL_W + ROW_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [9:0]    hcount,
    input  logic [9:0]    vcount,
    input  logic          h_act,
    input  logic          v_act,
    input  logic [2:0]    font_row,
    input  logic          hsync_in,
    input  logic          vsync_in,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic [5:0]    rgb,
    output logic          hsync_out,
    output logic          vsync_out
);
    localparam int LAT    = 3;
    localparam int CSH    = $clog2(CELL_W);
    localparam int PXSH   = $clog2(CELL_W / txt_pkg::GLYPH_W);

    logic [9:0]    row_full;
    logic [AW-1:0] rd_addr;
    logic [2:0]    subx;
    logic [7:0]    char_q, attr_q, font_q;
    logic [5:0]    fg_c, bg_c, fg_q, bg_q;
    logic [2:0]    subx_d1, subx_d2, fr_d1;
    logic          act_d1, act_d2;
    logic [1:0]    sync_pipe [LAT];

    // Cell address and glyph column from the raster counts.
    always_comb begin
        row_full = vcount / 10'(CELL_H);
        rd_addr  = {row_full[ROW_W-1:0], hcount[CSH +: COL_W]};
        subx     = hcount[PXSH +: 3];
    end

    txt_dpram #(.DEPTH(COLS*ROWS), .WIDTH(8)) i_char_ram (
        .clk(clk), .we(wr_en && !wr_sel), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(char_q));

    txt_dpram #(.DEPTH(COLS*ROWS), .WIDTH(8)) i_attr_ram (
        .clk(clk), .we(wr_en && wr_sel), .waddr(wr_addr), .wdata(wr_data),
        .raddr(rd_addr), .rdata(attr_q));

    txt_font_rom #(.NGLYPH(NGLYPH), .FONT_BITS(FONT_BITS)) i_font (
        .clk(clk), .code(char_q), .row(fr_d1), .bits(font_q));

    txt_palette #(.TABLE(FG_PAL)) i_fg_pal (.idx(attr_q[7:4]), .color(fg_c));
    txt_palette #(.TABLE(BG_PAL)) i_bg_pal (.idx(attr_q[3:0]), .color(bg_c));

    // Align glyph column, glyph row and active flag with the RAM/ROM reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            subx_d1 <= '0; subx_d2 <= '0; fr_d1 <= '0;
            act_d1  <= 1'b0; act_d2 <= 1'b0;
            fg_q    <= '0; bg_q <= '0;
        end else begin
            subx_d1 <= subx;     subx_d2 <= subx_d1;
            fr_d1   <= font_row;
            act_d1  <= h_act && v_act; act_d2 <= act_d1;
            fg_q    <= fg_c;     bg_q <= bg_c;
        end
    end

    // Pick foreground or background by glyph bit, black outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb <= '0;
        end else if (act_d2) begin
            rgb <= font_q[3'd7 - subx_d2] ? fg_q : bg_q;
        end else begin
            rgb <= '0;
        end
    end

    // Delay line for the two sync levels, one stage per pipeline register.
    for (genvar s = 0; s < LAT; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_pipe[s] <= 2'b00;
            end else if (s == 0) begin
                sync_pipe[s] <= {vsync_in, hsync_in};
            end else begin
                sync_pipe[s] <= sync_pipe[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign hsync_out = sync_pipe[LAT-1][0];
    assign vsync_out = sync_pipe[LAT-1][1];
endmodule

// File: rtl/txt_pixel_render_chk.sv
// txt_pixel_render_chk: temporal checks on the renderer's ports.
// Assumes a three-edge pixel latency; counts edges since reset so that no
// $past reaches before reset release.
module txt_pixel_render_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       h_act,
    input logic       v_act,
    input logic       hsync_in,
    input logic       vsync_in,
    input logic [5:0] rgb,
    input logic       hsync_out,
    input logic       vsync_out
);
    logic [1:0] since_rst = 2'd0;
    logic       clk_seen  = 1'b0;
    logic       warm;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        clk_seen <= 1'b1;
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign warm = (since_rst == 2'd3);

    // R1: a reset edge leaves outputs cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        (clk_seen && $past(!rst_n)) |-> (rgb == 6'd0 && !hsync_out && !vsync_out));

    // R6: outside the window the pixel is black three edges later.
    a_r6_black_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(h_act && v_act, 3)) |-> (rgb == 6'd0));

    // R7: horizontal sync delayed by the pixel latency.
    a_r7_hsync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (hsync_out == $past(hsync_in, 3)));

    // R7: vertical sync delayed by the pixel latency.
    a_r7_vsync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (vsync_out == $past(vsync_in, 3)));
endmodule

bind txt_pixel_render txt_pixel_render_chk i_chk (
    .clk(clk), .rst_n(rst_n), .h_act(h_act), .v_act(v_act),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .rgb(rgb),
    .hsync_out(hsync_out), .vsync_out(vsync_out));

// File: tb/test_txt_pixel_render.sv
module test_txt_pixel_render;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] hcount = '0, vcount = '0;
    logic       h_act = 1'b0, v_act = 1'b0;
    logic [2:0] font_row = '0;
    logic       hsync_in = 1'b0, vsync_in = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [8:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] rgb;
    logic       hsync_out, vsync_out;
    int         total = 0, bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    txt_pixel_render i_txt_pixel_render (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .h_act(h_act), .v_act(v_act), .font_row(font_row),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rgb(rgb), .hsync_out(hsync_out), .vsync_out(vsync_out));

    typedef struct packed {
        logic [4:0] col; logic [3:0] row; logic [2:0] gx; logic [2:0] fr;
        logic odd; logic [7:0] ch; logic [7:0] attr;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{5'd0,  4'd0,  3'd0, 3'd0, 1'b0, 8'd65,  8'h10},
        '{5'd1,  4'd0,  3'd7, 3'd3, 1'b1, 8'd66,  8'h21},
        '{5'd5,  4'd2,  3'd3, 3'd7, 1'b0, 8'd0,   8'h2F},
        '{5'd31, 4'd0,  3'd5, 3'd1, 1'b1, 8'd191, 8'h3C},
        '{5'd0,  4'd15, 3'd2, 3'd6, 1'b0, 8'd127, 8'hF0},
        '{5'd31, 4'd15, 3'd6, 3'd2, 1'b1, 8'd128, 8'h7A},
        '{5'd17, 4'd9,  3'd1, 3'd4, 1'b0, 8'd200, 8'h12},
        '{5'd9,  4'd7,  3'd4, 3'd5, 1'b1, 8'd32,  8'hE5}};

    localparam logic [5:0] PAL [16] = '{6'h00, 6'h3F, 6'h03, 6'h3C, 6'h33, 6'h0C,
        6'h30, 6'h0F, 6'h07, 6'h02, 6'h17, 6'h15, 6'h2A, 6'h3E, 6'h1C, 6'h2F};

    // Expected colour from the requirements (R3, R4, R5).
    function automatic logic [5:0] model(logic [7:0] ch, logic [7:0] attr,
                                         logic [2:0] fr, logic [2:0] gx);
        logic [7:0] fb;
        fb = (ch >= 8'd192) ? 8'h00 : (8'((int'(ch) * 8 + int'(fr)) % 256) ^ 8'h5A);
        return fb[7 - gx] ? PAL[attr[7:4]] : PAL[attr[3:0]];
    endfunction

    task automatic check(string req, logic [5:0] act, logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic write(logic sel, logic [8:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic place(logic [4:0] c, logic [3:0] r, logic [2:0] gx,
                         logic [2:0] fr, logic odd, logic ha, logic va);
        hcount = 10'(int'(c) * 16 + int'(gx) * 2 + int'(odd));
        vcount = 10'(int'(r) * 24 + int'(fr) * 3 + (odd ? 2 : 0));
        font_row = fr; h_act = ha; v_act = va;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        hsync_in = 1'b1; vsync_in = 1'b1;
        repeat (4) @(negedge clk);
        // R1: outputs cleared under reset
        check("R1 rgb", rgb, 6'h00);
        check("R1 sync", {4'b0, vsync_out, hsync_out}, 6'h00);
        hsync_in = 1'b0; vsync_in = 1'b0;
        rst_n = 1'b1;

        // R8: load both RAMs for every table cell
        foreach (VEC[i]) begin
            write(1'b0, {VEC[i].row, VEC[i].col}, VEC[i].ch);
            write(1'b1, {VEC[i].row, VEC[i].col}, VEC[i].attr);
        end

        // R2 R3 R4 R5: walk the table, sample three edges after presenting
        foreach (VEC[i]) begin
            @(negedge clk);
            place(VEC[i].col, VEC[i].row, VEC[i].gx, VEC[i].fr, VEC[i].odd, 1'b1, 1'b1);
            repeat (3) @(negedge clk);
            check("R3/R5 table", rgb,
                  model(VEC[i].ch, VEC[i].attr, VEC[i].fr, VEC[i].gx));
        end

        // R3: the other screen pixel of the doubled glyph pixel matches
        @(negedge clk);
        place(VEC[1].col, VEC[1].row, VEC[1].gx, VEC[1].fr, 1'b0, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R3 doubling", rgb, model(VEC[1].ch, VEC[1].attr, VEC[1].fr, VEC[1].gx));

        // R6: horizontal then vertical flag low gives black (cell 0 is white/black)
        @(negedge clk);
        place(5'd0, 4'd0, 3'd1, 3'd0, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R6 h outside", rgb, 6'h00);
        place(5'd0, 4'd0, 3'd1, 3'd0, 1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check("R6 v outside", rgb, 6'h00);

        // R8: write and display read of cell 0 in the same edge
        @(negedge clk);
        place(5'd0, 4'd0, 3'd0, 3'd0, 1'b0, 1'b1, 1'b1);
        wr_en = 1'b1; wr_sel = 1'b0; wr_addr = 9'd0; wr_data = 8'd90;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 old data", rgb, model(8'd65, 8'h10, 3'd0, 3'd0));
        @(negedge clk);
        check("R8 new data", rgb, model(8'd90, 8'h10, 3'd0, 3'd0));

        // R7/R2: one-cycle sync pulses emerge after three edges
        @(negedge clk);
        hsync_in = 1'b1; vsync_in = 1'b1;
        @(negedge clk);
        hsync_in = 1'b0; vsync_in = 1'b0;
        @(negedge clk);
        check("R7 not yet", {4'b0, vsync_out, hsync_out}, 6'h00);
        @(negedge clk);
        check("R7 pulse", {4'b0, vsync_out, hsync_out}, 6'h03);
        @(negedge clk);
        check("R7 pulse end", {4'b0, vsync_out, hsync_out}, 6'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule